// File: doc/BRIEF.md
# Main Clock Frequency Counter

This block estimates the rate of a fast main oscillator clock by comparing it with a slow reference clock of roughly 32 kHz. A rising edge on the oscillator-enable input arms one measurement. The block then opens a gate that lasts a fixed number of slow-clock periods, 16 by default. During that gate a counter in the main-clock domain counts main-clock rising edges.

When the gate closes, the main-domain count is frozen in a holding register and a toggle handshake passes it into the slow domain. There it is copied into a 32-bit status word that software can read. The main frequency is the count multiplied by (slow frequency / 16). For a 32 kHz reference, one count equals 2 kHz.

One enable edge yields exactly one result. After the result has been published, nothing more is measured until the enable input is dropped and raised again.

Top module: `main_freq_meter`

## Requirements
- R1: After reset, the status word reads 0x0000_0000.
- R2: The first slow-clock rising edge that samples the enable high after it was low, while no measurement is running, clears the whole status word to zero, including the ready flag at bit 16 and the count at bits 15:0.
- R3: The gate opens on the slow-clock edge after the one that saw the enable rise and lasts exactly 16 slow-clock periods. The published count in bits 15:0 equals the number of main-clock rising edges inside the gate, which is 16 × (main frequency / slow frequency).
- R4: Bit 16 (ready) is set in the same slow-clock cycle that the count is published. While ready is set, the count does not change unless a new measurement starts.
- R5: The count saturates at 0xFFFF and never wraps.
- R6: Bits 31:17 of the status word always read as zero.
- R7: After a result has been published, keeping the enable high, or lowering it, leaves the status word unchanged. Only a new low-to-high transition starts another measurement.
- R8: An enable rise that arrives while a measurement is already running, whether in the gate or waiting on the handshake, is ignored. The running measurement completes with its original gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Slow reference clock (about 32 kHz) |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| main_clk | input | 1 | Main oscillator clock being measured |
| main_rst_n | input | 1 | Active-low asynchronous reset, main domain |
| osc_en | input | 1 | Oscillator enable, sampled in the slow domain; a rise starts a measurement |
| status | output | 32 | {15'b0, ready, count[15:0]}, slow domain |

## Verification
Two functions can fall in the same period:
- a fresh enable rise on the slow side;
- a measurement that is still in flight, either with its gate open or with its handshake not yet returned.

The bench provokes this by dropping and raising the enable partway through a gate. It then judges the outcome at the ports: the ready flag must still arrive, and the published count must equal 16 times the main-to-slow period ratio of the original gate, neither restarted nor stretched. The bench also sweeps random period ratios with a fixed seed and runs one directed ratio whose count would exceed 16 bits, so that saturation is hit.

// File: rtl/main_freq_meter.sv
module main_freq_meter #(
  parameter int WIN_LOG2 = 4
) (
  input  logic        slow_clk,
  input  logic        slow_rst_n,
  input  logic        main_clk,
  input  logic        main_rst_n,
  input  logic        osc_en,
  output logic [31:0] status
);
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WIN_LOG2-1:0] PER_LAST = {WIN_LOG2{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_GATE, S_WAIT} st_t;

  st_t                st;
  logic               en_q, gate, ready;
  logic [WIN_LOG2-1:0] per;
  logic [CNT_W-1:0]   result;
  logic               ack1, ack2, ack3;

  logic               g1, g2, g3;
  logic [CNT_W-1:0]   cnt, hold;
  logic               done_t;

  wire en_rise = osc_en & ~en_q;

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      st <= S_IDLE; en_q <= 1'b0; gate <= 1'b0; ready <= 1'b0;
      per <= '0; result <= '0;
      ack1 <= 1'b0; ack2 <= 1'b0; ack3 <= 1'b0;
    end else begin
      en_q <= osc_en;
      ack1 <= done_t; ack2 <= ack1; ack3 <= ack2;
      unique case (st)
        S_IDLE: if (en_rise) begin
          ready <= 1'b0; result <= '0; st <= S_ARM;
        end
        S_ARM: begin
          gate <= 1'b1; per <= '0; st <= S_GATE;
        end
        S_GATE: begin
          per <= per + 1'b1;
          if (per == PER_LAST) begin
            gate <= 1'b0; st <= S_WAIT;
          end
        end
        S_WAIT: if (ack2 ^ ack3) begin
          result <= hold; ready <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge main_clk or negedge main_rst_n) begin
    if (!main_rst_n) begin
      g1 <= 1'b0; g2 <= 1'b0; g3 <= 1'b0;
      cnt <= '0; hold <= '0; done_t <= 1'b0;
    end else begin
      g1 <= gate; g2 <= g1; g3 <= g2;
      if (g2 && !g3)
        cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (g2 && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (!g2 && g3) begin
        hold <= cnt; done_t <= ~done_t;
      end
    end
  end

  assign status = {15'b0, ready, result};

  a_r2_clear_on_enable: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (st == S_IDLE && en_rise) |=> (status == 32'h0));

  a_r4_ready_holds: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (ready && !en_rise) |=> (ready && $stable(result)));

  a_r3_gate_length: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    $fell(gate) |-> ($past(per) == PER_LAST));

  a_r8_busy_ignores_enable: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (st != S_IDLE && en_rise) |=> (st != S_ARM));

  a_r5_saturate: assert property (@(posedge main_clk) disable iff (!main_rst_n)
    (g2 && g3 && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: tb/sim_main_freq_meter.sv
module sim_main_freq_meter;
  logic slow_clk = 1'b0, main_clk = 1'b0;
  logic slow_rst_n = 1'b0, main_rst_n = 1'b0, osc_en = 1'b0;
  logic [31:0] status;
  int slow_half = 40;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  main_freq_meter u0 (
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .main_clk(main_clk),
    .main_rst_n(main_rst_n), .osc_en(osc_en), .status(status)
  );

  always #10 main_clk = ~main_clk;
  initial begin
    #3;
    forever #(slow_half) slow_clk = ~slow_clk;
  end

  always @(posedge main_clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_count(int n);
    int f = 16 * n;
    return (f > 65535) ? 65535 : f;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 40 && !status[16]; i++) @(negedge slow_clk);
  endtask

  task automatic run_meas(int n, bit hold_chk);
    logic [31:0] snap;
    slow_half = n * 10;
    @(negedge slow_clk); osc_en = 1'b0;
    @(negedge slow_clk); @(negedge slow_clk); osc_en = 1'b1;
    @(negedge slow_clk);
    chk(status == 32'h0, "R2 status cleared on enable", status, 32'h0);
    wait_ready();
    chk(status[16] == 1'b1, "R4 ready set", {31'b0, status[16]}, 32'h1);
    chk(status[15:0] == exp_count(n)[15:0], (16 * n > 65535) ? "R5 saturated count" : "R3 count",
        {16'b0, status[15:0]}, exp_count(n));
    chk(status[31:17] == '0, "R6 upper bits zero", status, {15'b0, status[16:0]});
    if (hold_chk) begin
      snap = status;
      for (int i = 0; i < 24; i++) begin
        @(negedge slow_clk);
        if (i == 12) osc_en = 1'b0;
      end
      chk(status == snap, "R7 result held without new rise", status, snap);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0007));
    repeat (3) @(negedge slow_clk);
    slow_rst_n = 1'b1; main_rst_n = 1'b1;
    @(negedge slow_clk);
    chk(status == 32'h0, "R1 reset state", status, 32'h0);

    run_meas(4, 1'b1);
    run_meas(5, 1'b1);
    for (int k = 0; k < 6; k++) run_meas(4 + int'($urandom % 60), 1'b1);

    slow_half = 100;
    @(negedge slow_clk); osc_en = 1'b0;
    @(negedge slow_clk); osc_en = 1'b1;
    repeat (7) @(negedge slow_clk);
    osc_en = 1'b0;
    @(negedge slow_clk); osc_en = 1'b1;
    wait_ready();
    chk(status[16] == 1'b1, "R8 ready after mid-gate rise", {31'b0, status[16]}, 32'h1);
    chk(status[15:0] == 16'd160, "R8 original gate kept", {16'b0, status[15:0]}, 32'd160);

    run_meas(4096, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule